// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 64 peripheral interrupt lines and turns them into the two interrupt requests of a processor: a normal request (IRQ) and a fast request (FIQ). Every source owns one bit position in each status and control register. Software can enable each line, send it to the fast or the normal request, or raise it without any hardware event. Sixteen vector slots can each be bound to one source. An active bound source then produces a vectored IRQ, and the handler address is read from a single vector register.

Reading the vector register acknowledges the winning slot and marks it in service. From then on only slots of higher priority can interrupt. A write to the same register ends the service of the highest-priority slot in service and lets the lower slots through again. A protect bit, once set, limits register writes to privileged accesses. Unprivileged writes made while it is set change nothing.

Top module: `irqv_ctrl`

## Requirements
- R1: The raw status reads as the OR of the hardware line and the software bit for each source. Source n appears at bit n mod 32 of raw word n/32, at word index 0x00 for sources 0..31 and 0x01 for sources 32..63.
- R2: The IRQ status words (index 0x04/0x05) read raw AND enable AND NOT steer. The FIQ status words (index 0x02/0x03) read raw AND enable AND steer. Enable words are at 0x06/0x07 and steer words are at 0x08/0x09, where steer bit 1 means FIQ.
- R3: `fiq_o` is high exactly when an FIQ status bit is set. `irq_o` is high when an IRQ status bit is set and no slot is in service.
- R4: Writing 1 to a bit of the software words (index 0x0A/0x0B) raises that source with its hardware line low. Writing 0 removes it.
- R5: A line whose enable bit is 0 raises neither `irq_o` nor `fiq_o`.
- R6: Slot s takes its source index from bits 6:0 of its control register (index 0x20+s), is active when bit 7 is set, and has its handler address at index 0x10+s. Among the active bound sources with pending IRQ status, the lowest slot number wins, and its address appears on `vec_addr_o` and at the vector register (index 0x0D).
- R7: When only unbound IRQ sources are pending, the vector register returns the default address (index 0x0E).
- R8: A read of the vector register while a slot is eligible puts that slot in service. Pending requests of that slot, of lower slots and of unbound sources then no longer drive `irq_o`, but a higher slot still drives it.
- R9: A write to the vector register ends service of the highest-priority slot in service, and the slots below it become eligible again.
- R10: While the protect bit (index 0x0C, bit 0) is 1, a write with `bus_priv` low changes no register. Privileged writes always take effect, and when the protect bit is 0 unprivileged writes take effect too.
- R11: After reset, all control registers, the protect bit and the in-service state are zero, both requests are low and `vec_addr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Hardware interrupt lines, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (acknowledges at the vector register) |
| bus_priv | input | 1 | Access is privileged |
| bus_addr | input | 8 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on bus_addr |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| vec_addr_o | output | 32 | Current handler address |

## Verification
The hardest situation to reach is nested service. A slot must already be in service when a higher slot arrives, and the two end-of-service writes must then release the levels in the right order. The bench gets there by binding two sources to slots 2 and 5 together with one unbound source, and acknowledging slot 2. It then checks that both slot 5 and the unbound source are masked. After that it raises a third source bound to slot 0, acknowledges it, and removes it. The first end-of-service write must leave the request low and the second must bring slot 2's address back.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    localparam int DATA_W    = 32;
    localparam int MAX_SLOTS = 16;

    // register word indices
    localparam logic [7:0] OFS_RAW     = 8'h00;
    localparam logic [7:0] OFS_FIQST   = 8'h02;
    localparam logic [7:0] OFS_IRQST   = 8'h04;
    localparam logic [7:0] OFS_EN      = 8'h06;
    localparam logic [7:0] OFS_STEER   = 8'h08;
    localparam logic [7:0] OFS_SOFT    = 8'h0A;
    localparam logic [7:0] OFS_PROT    = 8'h0C;
    localparam logic [7:0] OFS_VEC     = 8'h0D;
    localparam logic [7:0] OFS_DEF     = 8'h0E;
    localparam logic [7:0] OFS_SLOTADR = 8'h10;
    localparam logic [7:0] OFS_SLOTCTL = 8'h20;

    typedef struct packed {
        logic       valid;
        logic [6:0] src;
    } slot_ctl_t;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic              priv;
        logic [7:0]        addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic       any;
        logic [3:0] idx;
    } pick_t;

    // lowest set bit wins
    function automatic pick_t pick_lowest(input logic [MAX_SLOTS-1:0] v);
        pick_t p;
        p = '0;
        for (int i = MAX_SLOTS - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.any = 1'b1;
                p.idx = 4'(i);
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/irqv_regs.sv
module irqv_regs
    import irqv_pkg::*;
#(
    parameter int NUM_SRC  = 64,
    parameter int NUM_SLOT = 16
) (
    input  logic                              clk,
    input  logic                              rst,
    input  bus_req_t                          req,
    output logic                              wr_ok,
    output logic [NUM_SRC-1:0]                en_q,
    output logic [NUM_SRC-1:0]                steer_q,
    output logic [NUM_SRC-1:0]                soft_q,
    output logic                              prot_q,
    output logic [DATA_W-1:0]                 def_q,
    output logic [NUM_SLOT-1:0][DATA_W-1:0]   slot_adr_q,
    output slot_ctl_t [NUM_SLOT-1:0]          slot_ctl_q
);
    localparam int WORDS = NUM_SRC / DATA_W;

    // protection gate: an unprivileged write is dropped while protected
    assign wr_ok = req.wr && (!prot_q || req.priv);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q       <= '0;
            steer_q    <= '0;
            soft_q     <= '0;
            prot_q     <= 1'b0;
            def_q      <= '0;
            slot_adr_q <= '0;
            slot_ctl_q <= '0;
        end else if (wr_ok) begin
            for (int w = 0; w < WORDS; w++) begin
                if (req.addr == OFS_EN + 8'(w))
                    en_q[w*DATA_W +: DATA_W] <= req.wdata;
                if (req.addr == OFS_STEER + 8'(w))
                    steer_q[w*DATA_W +: DATA_W] <= req.wdata;
                if (req.addr == OFS_SOFT + 8'(w))
                    soft_q[w*DATA_W +: DATA_W] <= req.wdata;
            end
            if (req.addr == OFS_PROT)
                prot_q <= req.wdata[0];
            if (req.addr == OFS_DEF)
                def_q <= req.wdata;
            for (int s = 0; s < NUM_SLOT; s++) begin
                if (req.addr == OFS_SLOTADR + 8'(s))
                    slot_adr_q[s] <= req.wdata;
                if (req.addr == OFS_SLOTCTL + 8'(s))
                    slot_ctl_q[s] <= slot_ctl_t'(req.wdata[7:0]);
            end
        end
    end

endmodule

// File: rtl/irqv_prio.sv
module irqv_prio
    import irqv_pkg::*;
#(
    parameter int NUM_SRC  = 64,
    parameter int NUM_SLOT = 16
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_SRC-1:0]               irq_stat,
    input  slot_ctl_t [NUM_SLOT-1:0]         slot_ctl,
    input  logic [NUM_SLOT-1:0][DATA_W-1:0]  slot_adr,
    input  logic [DATA_W-1:0]                def_adr,
    input  logic                             ack,
    input  logic                             eos,
    output logic [DATA_W-1:0]                vec_adr,
    output logic                             irq_req,
    output logic                             elig_any,
    output logic [NUM_SLOT-1:0]              insvc
);
    localparam int SRC_W = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0]   bound;
    logic [NUM_SLOT-1:0]  hit;
    logic [NUM_SLOT-1:0]  allowed;
    logic [NUM_SLOT-1:0]  elig;
    logic                 blocked;
    logic                 nonvec;
    pick_t                win;
    pick_t                top_svc;

    always_comb begin
        bound   = '0;
        hit     = '0;
        allowed = '0;
        blocked = 1'b0;
        for (int s = 0; s < NUM_SLOT; s++) begin
            if (slot_ctl[s].valid && (int'(slot_ctl[s].src) < NUM_SRC)) begin
                bound[slot_ctl[s].src[SRC_W-1:0]] = 1'b1;
                hit[s] = irq_stat[slot_ctl[s].src[SRC_W-1:0]];
            end
            // a slot in service blocks itself and every slot below it
            if (insvc[s])
                blocked = 1'b1;
            allowed[s] = !blocked;
        end
        elig     = hit & allowed;
        nonvec   = |(irq_stat & ~bound);
        win      = pick_lowest(MAX_SLOTS'(elig));
        top_svc  = pick_lowest(MAX_SLOTS'(insvc));
        elig_any = win.any;
        vec_adr  = win.any ? slot_adr[win.idx] : def_adr;
        irq_req  = win.any || (nonvec && (insvc == '0));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            insvc <= '0;
        end else if (ack && win.any) begin
            insvc[win.idx] <= 1'b1;
        end else if (eos && top_svc.any) begin
            insvc[top_svc.idx] <= 1'b0;
        end
    end

endmodule

// File: rtl/irqv_ctrl.sv
module irqv_ctrl
    import irqv_pkg::*;
#(
    parameter int NUM_SRC  = 64,   // multiple of 32, at most 64
    parameter int NUM_SLOT = 16    // at most 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SRC-1:0]   src_i,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic                 bus_priv,
    input  logic [7:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 irq_o,
    output logic                 fiq_o,
    output logic [31:0]          vec_addr_o
);
    localparam int WORDS = NUM_SRC / DATA_W;

    bus_req_t                         req;
    logic                             wr_ok;
    logic [NUM_SRC-1:0]               en_q;
    logic [NUM_SRC-1:0]               steer_q;
    logic [NUM_SRC-1:0]               soft_q;
    logic                             prot_q;
    logic [DATA_W-1:0]                def_q;
    logic [NUM_SLOT-1:0][DATA_W-1:0]  slot_adr_q;
    slot_ctl_t [NUM_SLOT-1:0]         slot_ctl_q;
    logic [NUM_SRC-1:0]               raw;
    logic [NUM_SRC-1:0]               fiq_stat;
    logic [NUM_SRC-1:0]               irq_stat;
    logic [NUM_SLOT-1:0]              insvc;
    logic                             elig_any;
    logic                             irq_req;
    logic                             ack;
    logic                             eos;

    assign req = '{wr: bus_wr, rd: bus_rd, priv: bus_priv,
                   addr: bus_addr, wdata: bus_wdata};

    irqv_regs #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .wr_ok      (wr_ok),
        .en_q       (en_q),
        .steer_q    (steer_q),
        .soft_q     (soft_q),
        .prot_q     (prot_q),
        .def_q      (def_q),
        .slot_adr_q (slot_adr_q),
        .slot_ctl_q (slot_ctl_q)
    );

    assign raw      = src_i | soft_q;
    assign fiq_stat = raw & en_q & steer_q;
    assign irq_stat = raw & en_q & ~steer_q;

    assign ack = bus_rd && (bus_addr == OFS_VEC);
    assign eos = wr_ok && (bus_addr == OFS_VEC);

    irqv_prio #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT)) u_prio (
        .clk      (clk),
        .rst      (rst),
        .irq_stat (irq_stat),
        .slot_ctl (slot_ctl_q),
        .slot_adr (slot_adr_q),
        .def_adr  (def_q),
        .ack      (ack),
        .eos      (eos),
        .vec_adr  (vec_addr_o),
        .irq_req  (irq_req),
        .elig_any (elig_any),
        .insvc    (insvc)
    );

    assign irq_o = irq_req;
    assign fiq_o = |fiq_stat;

    always_comb begin
        bus_rdata = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (bus_addr == OFS_RAW + 8'(w))   bus_rdata = raw[w*DATA_W +: DATA_W];
            if (bus_addr == OFS_FIQST + 8'(w)) bus_rdata = fiq_stat[w*DATA_W +: DATA_W];
            if (bus_addr == OFS_IRQST + 8'(w)) bus_rdata = irq_stat[w*DATA_W +: DATA_W];
            if (bus_addr == OFS_EN + 8'(w))    bus_rdata = en_q[w*DATA_W +: DATA_W];
            if (bus_addr == OFS_STEER + 8'(w)) bus_rdata = steer_q[w*DATA_W +: DATA_W];
            if (bus_addr == OFS_SOFT + 8'(w))  bus_rdata = soft_q[w*DATA_W +: DATA_W];
        end
        if (bus_addr == OFS_PROT) bus_rdata = {31'b0, prot_q};
        if (bus_addr == OFS_VEC)  bus_rdata = vec_addr_o;
        if (bus_addr == OFS_DEF)  bus_rdata = def_q;
        for (int s = 0; s < NUM_SLOT; s++) begin
            if (bus_addr == OFS_SLOTADR + 8'(s)) bus_rdata = slot_adr_q[s];
            if (bus_addr == OFS_SLOTCTL + 8'(s)) bus_rdata = {24'b0, slot_ctl_q[s]};
        end
    end

endmodule

// File: rtl/irqv_ctrl_chk.sv
module irqv_ctrl_chk
    import irqv_pkg::*;
#(
    parameter int NUM_SRC  = 64,
    parameter int NUM_SLOT = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic                bus_priv,
    input logic [7:0]          bus_addr,
    input logic                irq_o,
    input logic                fiq_o,
    input logic                wr_ok,
    input logic                elig_any,
    input logic                prot_q,
    input logic [NUM_SRC-1:0]  en_q,
    input logic [NUM_SRC-1:0]  steer_q,
    input logic [NUM_SRC-1:0]  soft_q,
    input logic [NUM_SLOT-1:0] insvc
);
    AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |-> (!irq_o && !fiq_o)); // R5

    AST_FIQ_NEEDS_STEER: assert property (@(posedge clk) disable iff (rst)
        fiq_o |-> (|(en_q & steer_q))); // R3

    AST_PROT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (prot_q && bus_wr && !bus_priv) |=>
        ($stable(en_q) && $stable(steer_q) && $stable(soft_q) && $stable(prot_q))); // R10

    AST_ACK_NESTS: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr == OFS_VEC && elig_any) |=>
        ($countones(insvc) == $past($countones(insvc)) + 1)); // R8

    AST_EOS_POPS: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && !bus_rd && bus_addr == OFS_VEC && insvc != '0) |=>
        ($countones(insvc) + 1 == $past($countones(insvc)))); // R9

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (insvc == '0 && !prot_q && en_q == '0)); // R11
endmodule

bind irqv_ctrl irqv_ctrl_chk #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_priv (bus_priv),
    .bus_addr (bus_addr),
    .irq_o    (irq_o),
    .fiq_o    (fiq_o),
    .wr_ok    (wr_ok),
    .elig_any (elig_any),
    .prot_q   (prot_q),
    .en_q     (en_q),
    .steer_q  (steer_q),
    .soft_q   (soft_q),
    .insvc    (insvc)
);

// File: tb/irqv_ctrl_bench.sv
module irqv_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] src_i = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_priv = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic        fiq_o;
    logic [31:0] vec_addr_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    irqv_ctrl u_irqv_ctrl (
        .clk        (clk),
        .rst        (rst),
        .src_i      (src_i),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_priv   (bus_priv),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_o      (irq_o),
        .fiq_o      (fiq_o),
        .vec_addr_o (vec_addr_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic priv);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_priv = priv;
        @(posedge clk);
        #1 bus_wr = 1'b0; bus_priv = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic set_src(input logic [63:0] v);
        @(negedge clk);
        src_i = v;
    endtask

    task automatic look(input string req, input logic irq, input logic fiq);
        @(negedge clk);
        check({req, " irq_o"}, 32'(irq_o), 32'(irq));
        check({req, " fiq_o"}, 32'(fiq_o), 32'(fiq));
    endtask

    task automatic t_reset();
        logic [31:0] d;
        look("R11", 1'b0, 1'b0);
        check("R11 vec_addr_o", vec_addr_o, 32'h0);
        rd(8'h06, d); check("R11 enable word", d, 32'h0);
        rd(8'h0C, d); check("R11 protect", d, 32'h0);
    endtask

    task automatic t_raw();
        logic [31:0] d;
        set_src(64'h8000_0001_0000_0004);
        rd(8'h00, d); check("R1 raw word0", d, 32'h0000_0004);
        rd(8'h01, d); check("R1 raw word1", d, 32'h8000_0001);
        look("R5", 1'b0, 1'b0);
        rd(8'h04, d); check("R2 irq status disabled", d, 32'h0);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        wr(8'h06, 32'h4, 1'b1);
        look("R3 irq path", 1'b1, 1'b0);
        rd(8'h04, d); check("R2 irq status", d, 32'h4);
        rd(8'h02, d); check("R2 fiq status empty", d, 32'h0);
        wr(8'h08, 32'h4, 1'b1);
        look("R3 fiq path", 1'b0, 1'b1);
        rd(8'h02, d); check("R2 fiq status", d, 32'h4);
        wr(8'h08, 32'h0, 1'b1);
        wr(8'h06, 32'h0, 1'b1);
        set_src('0);
        look("R5 cleared", 1'b0, 1'b0);
    endtask

    task automatic t_soft();
        logic [31:0] d;
        wr(8'h07, 32'h10, 1'b1);
        wr(8'h0B, 32'h10, 1'b1);
        look("R4 soft raise", 1'b1, 1'b0);
        rd(8'h01, d); check("R4 raw word1", d, 32'h10);
        wr(8'h0B, 32'h0, 1'b1);
        look("R4 soft drop", 1'b0, 1'b0);
        wr(8'h07, 32'h0, 1'b1);
    endtask

    task automatic t_prio();
        wr(8'h0E, 32'hD0, 1'b1);
        wr(8'h22, 32'h80 | 32'd9, 1'b1);
        wr(8'h12, 32'h200, 1'b1);
        wr(8'h25, 32'h80 | 32'd3, 1'b1);
        wr(8'h15, 32'h500, 1'b1);
        wr(8'h06, 32'h0010_1208, 1'b1);
        set_src(64'h208);
        look("R6", 1'b1, 1'b0);
        check("R6 slot2 wins", vec_addr_o, 32'h200);
        set_src(64'h8);
        @(negedge clk);
        check("R6 slot5 alone", vec_addr_o, 32'h500);
        set_src(64'h10_0000);
        look("R7", 1'b1, 1'b0);
        check("R7 default address", vec_addr_o, 32'hD0);
        set_src(64'h10_0208);
    endtask

    task automatic t_nest();
        logic [31:0] d;
        rd(8'h0D, d); check("R8 ack returns slot2", d, 32'h200);
        look("R8 lower and unbound masked", 1'b0, 1'b0);
        check("R8 vec after ack", vec_addr_o, 32'hD0);
        wr(8'h20, 32'h80 | 32'd12, 1'b1);
        wr(8'h10, 32'h100, 1'b1);
        set_src(64'h10_1208);
        look("R8 preempt", 1'b1, 1'b0);
        check("R8 preempt vec", vec_addr_o, 32'h100);
        rd(8'h0D, d); check("R8 ack slot0", d, 32'h100);
        set_src(64'h10_0208);
        look("R8 nested quiet", 1'b0, 1'b0);
        wr(8'h0D, 32'h0, 1'b1);
        look("R9 first eos keeps slot2", 1'b0, 1'b0);
        wr(8'h0D, 32'h0, 1'b1);
        look("R9 second eos restores", 1'b1, 1'b0);
        check("R9 vec after eos", vec_addr_o, 32'h200);
    endtask

    task automatic t_protect();
        logic [31:0] d;
        wr(8'h0C, 32'h1, 1'b1);
        wr(8'h06, 32'h0, 1'b0);
        rd(8'h06, d); check("R10 enable kept", d, 32'h0010_1208);
        look("R10 request kept", 1'b1, 1'b0);
        wr(8'h0C, 32'h0, 1'b0);
        rd(8'h0C, d); check("R10 protect kept", d, 32'h1);
        wr(8'h06, 32'h0, 1'b1);
        look("R10 privileged write", 1'b0, 1'b0);
        wr(8'h0C, 32'h0, 1'b1);
        wr(8'h06, 32'h8, 1'b0);
        rd(8'h06, d); check("R10 unprotected write", d, 32'h8);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_raw();
        t_mask();
        t_soft();
        t_prio();
        t_nest();
        t_protect();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule